// File: doc/BRIEF.md
# Trace Status Compressor

This block sits beside a processor core and turns its per-cycle status events into a compact stream of 6-bit trace entries. The events are instruction completions, taken branches, exception entry, return from exception, and changes of flow that carry a captured target address. A debugger later reads the stream out of a 64-entry circular buffer. Each event becomes zero or more entries. A run of sequential completions is folded into one count entry. A captured 16-bit target is split into four tagged nibble entries.

One event can yield up to seven entries in a single cycle. These go into a small internal queue, which drains into the buffer one entry per cycle, so order is kept. The debugger side has a combinational read port indexed by location. It also sees the current write pointer and a sticky flag that says the buffer has filled at least once. A synchronous clear restarts recording without erasing stored entries.

Top module: `trace_packer`

## Requirements
- R1: Entries are 6 bits and are written to consecutive buffer locations in production order. `wr_ptr` names the next location to be written. `rd_data` returns the entry stored at `rd_idx`.
- R2: Sequential completions (`evt_kind` 0) are counted, not written. A run of N (1 to 14) is written as one entry 0x10+N, just before the entries of the next event that produces entries.
- R3: When a run reaches 15, entry 0x1F is produced in the same cycle as the 15th completion, and counting restarts at zero.
- R4: A taken branch (`evt_kind` 1) produces entry 0x05.
- R5: Exception entry (`evt_kind` 2) produces two entries of 0x1C.
- R6: Return from exception (`evt_kind` 3) produces 0x07 followed by 0x03.
- R7: A change of flow with a captured target (`evt_kind` 4) while `addr_show_en` is 1 produces 0x05, then 0x0D, then four entries 0x20|nibble of `evt_addr`, least significant nibble first.
- R8: `evt_kind` 4 while `addr_show_en` is 0 produces only 0x05.
- R9: Operand events (`evt_kind` 5) and the unused codes 6 and 7 produce no entries and leave a pending run uncounted and unflushed.
- R10: Kinds 1 to 4 always flush a pending run first and leave the run count at zero.
- R11: After location 63 the pointer returns to 0, overwriting the oldest data. `wrapped` becomes 1 on that write and stays 1.
- R12: `clr` (and `rst`) return `wr_ptr` to 0, `wrapped` to 0, drop the pending run and discard queued entries. An event in the same cycle as `clr` is ignored. Stored entries are not erased.
- R13: An event sampled at clock edge t with an empty queue has its first entry stored at edge t+1. Further entries follow one per edge, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of pointer, flag, run and queue |
| evt_valid | input | 1 | Status event present this cycle |
| evt_kind | input | 3 | Event type code (0 to 5 used) |
| evt_addr | input | 16 | Captured target address for kind 4 |
| addr_show_en | input | 1 | Enables target address entries |
| rd_idx | input | 6 | Debugger read location |
| rd_data | output | 6 | Entry stored at `rd_idx` |
| wr_ptr | output | 6 | Next location to be written |
| wrapped | output | 1 | Buffer has filled at least once |

## Verification
The hardest case to reach is a queue that is already holding entries when the next multi-entry event arrives, with a run flush inserted ahead of that event's own entries. A clear that lands while such a backlog is waiting is harder still. Directed back-to-back events build the backlog on purpose. A long random phase then paces the seven-entry events by the reference queue's depth, so the queue runs close to full without overflowing, and it throws in occasional clears that arrive mid-backlog.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int ENT_W     = 6;
    localparam int ADDR_W    = 16;
    localparam int NIB_N     = ADDR_W / 4;
    localparam int MAX_BURST = 3 + NIB_N;   // flush + 0x05 + 0x0D + nibbles
    localparam int BURST_W   = $clog2(MAX_BURST + 1);
    localparam int RUN_LIMIT = 15;

    typedef logic [ENT_W-1:0] entry_t;

    typedef enum logic [2:0] {
        EV_SEQ     = 3'd0,
        EV_BRANCH  = 3'd1,
        EV_EXC     = 3'd2,
        EV_RTE     = 3'd3,
        EV_TARGET  = 3'd4,
        EV_OPERAND = 3'd5
    } evt_kind_e;

    typedef struct packed {
        logic              valid;
        evt_kind_e         kind;
        logic [ADDR_W-1:0] addr;
    } evt_t;

    localparam entry_t CODE_BRANCH = 6'h05;
    localparam entry_t CODE_EXC    = 6'h1C;
    localparam entry_t CODE_RTE_A  = 6'h07;
    localparam entry_t CODE_RTE_B  = 6'h03;
    localparam entry_t CODE_MARK   = 6'h0D;

    function automatic entry_t run_code(input logic [3:0] n);
        return 6'h10 | {2'b00, n};
    endfunction

    function automatic entry_t nib_code(input logic [3:0] n);
        return 6'h20 | {2'b00, n};
    endfunction

endpackage

// File: rtl/trace_encoder.sv
module trace_encoder
    import trace_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  evt_t                          evt,
    input  logic                          addr_show_en,
    output entry_t [MAX_BURST-1:0]        ents,
    output logic   [BURST_W-1:0]          n_ents
);

    logic [3:0]              run_q, run_d;
    entry_t [MAX_BURST-2:0]  body;
    logic [BURST_W-1:0]      body_n;
    logic                    cof;
    logic                    flush;

    always_comb begin
        body   = '0;
        body_n = '0;
        run_d  = run_q;
        cof    = 1'b0;
        if (evt.valid) begin
            case (evt.kind)
                EV_SEQ: begin
                    if (run_q == 4'(RUN_LIMIT - 1)) begin
                        body[0] = run_code(4'(RUN_LIMIT));
                        body_n  = BURST_W'(1);
                        run_d   = '0;
                    end else begin
                        run_d = run_q + 4'd1;
                    end
                end
                EV_BRANCH: begin
                    cof     = 1'b1;
                    body[0] = CODE_BRANCH;
                    body_n  = BURST_W'(1);
                end
                EV_EXC: begin
                    cof     = 1'b1;
                    body[0] = CODE_EXC;
                    body[1] = CODE_EXC;
                    body_n  = BURST_W'(2);
                end
                EV_RTE: begin
                    cof     = 1'b1;
                    body[0] = CODE_RTE_A;
                    body[1] = CODE_RTE_B;
                    body_n  = BURST_W'(2);
                end
                EV_TARGET: begin
                    cof     = 1'b1;
                    body[0] = CODE_BRANCH;
                    body_n  = BURST_W'(1);
                    if (addr_show_en) begin
                        body[1] = CODE_MARK;
                        for (int i = 0; i < NIB_N; i++) begin
                            body[2+i] = nib_code(evt.addr[4*i +: 4]);
                        end
                        body_n = BURST_W'(2 + NIB_N);
                    end
                end
                default: ;
            endcase
            if (cof) run_d = '0;
        end
    end

    assign flush = cof && (run_q != 4'd0);

    always_comb begin
        ents[0] = flush ? run_code(run_q) : body[0];
        for (int i = 1; i < MAX_BURST - 1; i++) begin
            ents[i] = flush ? body[i-1] : body[i];
        end
        ents[MAX_BURST-1] = flush ? body[MAX_BURST-2] : '0;
        n_ents = body_n + BURST_W'(flush);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) run_q <= '0;
        else            run_q <= run_d;
    end

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q < 4'(RUN_LIMIT));

    // R10
    run_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.kind inside {EV_BRANCH, EV_EXC, EV_RTE, EV_TARGET}) |=> run_q == 4'd0);

endmodule

// File: rtl/trace_fifo.sv
module trace_fifo
    import trace_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  entry_t [MAX_BURST-1:0]        push_ents,
    input  logic   [BURST_W-1:0]          push_n,
    output entry_t                        head_ent,
    output logic                          head_vld
);

    localparam int AW = $clog2(DEPTH);

    entry_t          store [DEPTH];
    logic [AW-1:0]   head, tail;
    logic [AW:0]     count;

    assign head_vld = (count != '0);
    assign head_ent = store[head];

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_BURST; i++) begin
            if (BURST_W'(i) < push_n) store[tail + AW'(i)] <= push_ents[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            tail  <= tail + AW'(push_n);
            head  <= head + AW'(head_vld);
            count <= count + (AW+1)'(push_n) - (AW+1)'(head_vld);
        end
    end

    // R13
    fifo_room_chk: assert property (@(posedge clk) disable iff (rst || clr)
        int'(push_n) <= DEPTH - int'(count) + int'(head_vld));

endmodule

// File: rtl/trace_ring.sv
module trace_ring
    import trace_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         we,
    input  entry_t                       wr_ent,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output entry_t                       rd_data,
    output logic [$clog2(DEPTH)-1:0]     ptr,
    output logic                         wrapped
);

    localparam int PW = $clog2(DEPTH);

    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && !clr) mem[ptr] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr     <= '0;
            wrapped <= 1'b0;
        end else if (we) begin
            ptr <= ptr + PW'(1);
            if (ptr == PW'(DEPTH - 1)) wrapped <= 1'b1;
        end
    end

    assign rd_data = mem[rd_idx];

    // R1
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !clr) |=> ptr == $past(ptr) + PW'(1));

    // R11
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wrapped && !clr) |=> wrapped);

    // R12
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0) && !wrapped);

endmodule

// File: rtl/trace_packer.sv
module trace_packer
    import trace_pkg::*;
#(
    parameter int BUF_DEPTH   = 64,
    parameter int QUEUE_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          evt_valid,
    input  logic [2:0]                    evt_kind,
    input  logic [15:0]                   evt_addr,
    input  logic                          addr_show_en,
    input  logic [$clog2(BUF_DEPTH)-1:0]  rd_idx,
    output logic [5:0]                    rd_data,
    output logic [$clog2(BUF_DEPTH)-1:0]  wr_ptr,
    output logic                          wrapped
);

    evt_t                    evt;
    entry_t [MAX_BURST-1:0]  ents;
    logic   [BURST_W-1:0]    n_ents;
    entry_t                  head_ent;
    logic                    head_vld;

    assign evt.valid = evt_valid && !clr;
    assign evt.kind  = evt_kind_e'(evt_kind);
    assign evt.addr  = evt_addr;

    trace_encoder u_enc (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .evt          (evt),
        .addr_show_en (addr_show_en),
        .ents         (ents),
        .n_ents       (n_ents)
    );

    trace_fifo #(.DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .push_ents (ents),
        .push_n    (n_ents),
        .head_ent  (head_ent),
        .head_vld  (head_vld)
    );

    trace_ring #(.DEPTH(BUF_DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .we      (head_vld),
        .wr_ent  (head_ent),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .ptr     (wr_ptr),
        .wrapped (wrapped)
    );

endmodule

// File: tb/trace_packer_bench.sv
module trace_packer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        evt_valid = 1'b0;
    logic [2:0]  evt_kind = 3'd0;
    logic [15:0] evt_addr = 16'd0;
    logic        addr_show_en = 1'b0;
    logic [5:0]  rd_idx = 6'd0;
    logic [5:0]  rd_data;
    logic [5:0]  wr_ptr;
    logic        wrapped;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    trace_packer u_trace_packer (
        .clk(clk), .rst(rst), .clr(clr), .evt_valid(evt_valid),
        .evt_kind(evt_kind), .evt_addr(evt_addr), .addr_show_en(addr_show_en),
        .rd_idx(rd_idx), .rd_data(rd_data), .wr_ptr(wr_ptr), .wrapped(wrapped)
    );

    // behavioural reference
    logic [5:0] mq[$];
    logic [5:0] mmem [64];
    bit         mvld [64];
    int         mptr = 0;
    bit         mwrap = 0;
    int         mrun = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_event(int k, int a, bit show);
        if (k == 0) begin
            mrun++;
            if (mrun == 15) begin mq.push_back(6'h1F); mrun = 0; end
        end else if (k >= 1 && k <= 4) begin
            if (mrun != 0) mq.push_back(6'(6'h10 + mrun));
            mrun = 0;
            case (k)
                1: mq.push_back(6'h05);
                2: begin mq.push_back(6'h1C); mq.push_back(6'h1C); end
                3: begin mq.push_back(6'h07); mq.push_back(6'h03); end
                default: begin
                    mq.push_back(6'h05);
                    if (show) begin
                        mq.push_back(6'h0D);
                        for (int i = 0; i < 4; i++) mq.push_back(6'(6'h20 | ((a >> (4*i)) & 15)));
                    end
                end
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (rst || clr) begin
            mptr = 0; mwrap = 0; mrun = 0; mq.delete();
        end else begin
            if (mq.size() != 0) begin
                mmem[mptr] = mq.pop_front();
                mvld[mptr] = 1'b1;
                if (mptr == 63) mwrap = 1'b1;
                mptr = (mptr + 1) % 64;
            end
            if (evt_valid) model_event(int'(evt_kind), int'(evt_addr), addr_show_en);
        end
        #5;
        if (!rst) begin
            check(int'(wr_ptr) == mptr, "R1 wr_ptr", int'(wr_ptr), mptr);
            check(wrapped == mwrap, "R11 wrapped", int'(wrapped), int'(mwrap));
            if (mvld[rd_idx])
                check(rd_data == mmem[rd_idx], "R1 rd_data", int'(rd_data), int'(mmem[rd_idx]));
        end
    end

    task automatic put(int k, int a);
        evt_valid = 1'b1; evt_kind = 3'(k); evt_addr = 16'(a);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic peek(int idx, int exp, string tag);
        rd_idx = 6'(idx);
        #1;
        check(int'(rd_data) == exp, tag, int'(rd_data), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(wr_ptr == 6'd0, "R12 reset wr_ptr", int'(wr_ptr), 0);
        check(wrapped == 1'b0, "R12 reset wrapped", int'(wrapped), 0);

        // R13 latency with an empty queue
        put(2, 0);
        check(wr_ptr == 6'd0, "R13 not yet stored", int'(wr_ptr), 0);
        @(negedge clk);
        check(wr_ptr == 6'd1, "R13 first entry", int'(wr_ptr), 1);
        @(negedge clk);
        check(wr_ptr == 6'd2, "R13 second entry", int'(wr_ptr), 2);

        // R11 wraparound
        do_clear();
        for (int i = 0; i < 63; i++) put(1, 0);
        idle(3);
        check(wr_ptr == 6'd63 && !wrapped, "R11 before wrap", int'({wrapped, wr_ptr}), 63);
        put(1, 0);
        idle(3);
        check(wr_ptr == 6'd0, "R11 ptr wraps", int'(wr_ptr), 0);
        check(wrapped == 1'b1, "R11 flag set", int'(wrapped), 1);

        // R12 clear with pending run and a simultaneous event
        put(0, 0); put(0, 0); put(0, 0);
        clr = 1'b1; evt_valid = 1'b1; evt_kind = 3'd2;
        @(negedge clk);
        clr = 1'b0; evt_valid = 1'b0;
        check(wr_ptr == 6'd0 && !wrapped, "R12 clear state", int'({wrapped, wr_ptr}), 0);
        put(1, 0);
        idle(3);
        peek(0, 6'h05, "R12 run dropped");
        check(wr_ptr == 6'd1, "R12 event ignored", int'(wr_ptr), 1);

        // directed back-to-back sequence
        do_clear();
        addr_show_en = 1'b1;
        put(0, 0); put(0, 0); put(0, 0); put(1, 0);
        put(0, 0); put(0, 0); put(2, 0);
        put(3, 0);
        put(4, 16'h5432);
        addr_show_en = 1'b0;
        put(4, 16'h5432);
        for (int i = 0; i < 15; i++) put(0, 0);
        put(0, 0); put(5, 0); put(7, 0); put(0, 0); put(1, 0);
        idle(20);
        peek(0, 6'h13, "R2 run of three");
        peek(1, 6'h05, "R4 branch");
        peek(2, 6'h12, "R10 flush before exception");
        peek(3, 6'h1C, "R5 exception first");
        peek(4, 6'h1C, "R5 exception second");
        peek(5, 6'h07, "R6 return first");
        peek(6, 6'h03, "R6 return second");
        peek(7, 6'h05, "R7 cof code");
        peek(8, 6'h0D, "R7 address marker");
        peek(9, 6'h22, "R7 nibble 0");
        peek(10, 6'h23, "R7 nibble 1");
        peek(11, 6'h24, "R7 nibble 2");
        peek(12, 6'h25, "R7 nibble 3");
        peek(13, 6'h05, "R8 no address");
        peek(14, 6'h1F, "R3 run limit");
        peek(15, 6'h12, "R9 operand ignored");
        peek(16, 6'h05, "R4 branch after run");
        check(wr_ptr == 6'd17, "R9 entry count", int'(wr_ptr), 17);
        do_clear();
        peek(16, 6'h05, "R12 contents kept");
        peek(8, 6'h0D, "R12 contents kept");

        // random phase, paced by the reference queue depth
        for (int c = 0; c < 3000; c++) begin
            int r;
            r = int'($urandom % 10);
            addr_show_en = 1'($urandom);
            rd_idx = 6'($urandom);
            if ($urandom % 200 == 0) begin
                do_clear();
            end else if (mq.size() >= 8 && r >= 4 && r <= 7) begin
                @(negedge clk);
            end else if (r < 4) put(0, 0);
            else if (r <= 7) put(r - 3, int'($urandom));
            else if (r == 8) put(5 + int'($urandom % 3), 0);
            else @(negedge clk);
        end
        idle(20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule